// File: doc/BRIEF.md
# Banked Dual-Port Load Arbiter

This block is the read front end of a banked data cache array. Two load ports can each present one 128-bit load per cycle. Each load is steered to one of sixteen banks, and each bank is one 16-byte word wide. A bank has a single read port. When both loads fall in the same bank in the same cycle, port 0 is served and port 1 is told to replay. The caller must present the port 1 load again in a later cycle. Loads that fall in different banks are both served in that cycle. Tags are not modelled and every load is treated as a hit.

Each served load returns its full bank word on its own port a fixed four cycles later. The returned data passes through a short pipeline that recomputes one parity bit per byte and compares it with the stored parity. Any mismatch raises an error flag in the same cycle as the data. A write port used only for initialization fills bank words and generates their parity. It has a per-byte parity inversion mask so that corrupted entries can be planted.

Top module: `bank_load_arb`

## Requirements
- R1: A load address selects the bank with bits [7:4] and the row with bits [11:8]. Bits [3:0] do not affect which word is returned, and a load returns the whole 16-byte word last filled at that bank and row.
- R2: When both ports request loads to different banks in the same cycle, both are granted and each port returns its own word.
- R3: When both ports request the same bank in one cycle, `ld0_gnt` is 1, `ld1_gnt` is 0 and `ld1_replay` is 1 in that same cycle.
- R4: A valid port 0 request is always granted in the cycle it is presented. A port 1 request with port 0 idle is always granted.
- R5: `rdN_valid` is high in exactly the fourth cycle after a cycle in which `ldN_gnt` was high, and low in every other cycle.
- R6: A fill write uses the same bank and row bits as a load. It stores the data together with one parity bit per byte, equal to the XOR of that byte's eight bits XOR the matching bit of `fill_par_flip`.
- R7: `rdN_perr` is 1 with returned data exactly when at least one byte's stored parity differs from the parity recomputed from the returned byte. It is never 1 while `rdN_valid` is 0.
- R8: While reset is held and in the cycle after it is released, `rd0_valid`, `rd1_valid`, `rd0_perr` and `rd1_perr` are 0.
- R9: `ld1_replay` is 0 in any cycle without a same-bank conflict, including cycles where port 1 is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_en | input | 1 | Initialization write enable |
| fill_addr | input | 12 | Initialization write address (bank [7:4], row [11:8]) |
| fill_data | input | 128 | Initialization write word |
| fill_par_flip | input | 16 | Per-byte mask that inverts generated parity bits |
| ld0_req | input | 1 | Port 0 load request |
| ld0_addr | input | 12 | Port 0 load address |
| ld1_req | input | 1 | Port 1 load request |
| ld1_addr | input | 12 | Port 1 load address |
| ld0_gnt | output | 1 | Port 0 load accepted this cycle |
| ld1_gnt | output | 1 | Port 1 load accepted this cycle |
| ld1_replay | output | 1 | Port 1 lost a bank conflict and must present the load again |
| rd0_valid | output | 1 | Port 0 return data valid |
| rd0_data | output | 128 | Port 0 return word |
| rd0_perr | output | 1 | Port 0 return parity error |
| rd1_valid | output | 1 | Port 1 return data valid |
| rd1_data | output | 128 | Port 1 return word |
| rd1_perr | output | 1 | Port 1 return parity error |

## Verification
The hardest situations to reach from the ports are a parity mismatch and a chain of consecutive same-bank conflicts in which port 1 keeps replaying while port 0 keeps winning. Parity errors are planted during initialization through the parity inversion mask on a random subset of entries and on one directed entry, and those entries are then loaded. Conflict chains are made frequent by drawing most bank numbers from a pool of three. Whenever port 1 is told to replay, the bench presents the same port 1 address again on the next cycle, so back-to-back conflicts and their independent returns occur many times.

// File: rtl/lda_pkg.sv
package lda_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LOAD_LAT = 4;
endpackage

// File: rtl/bank_arb.sv
module bank_arb #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned ROW_W     = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req0,
  input  logic [BANK_W-1:0]                bank0,
  input  logic [ROW_W-1:0]                 row0,
  input  logic                             req1,
  input  logic [BANK_W-1:0]                bank1,
  input  logic [ROW_W-1:0]                 row1,
  output logic                             gnt0,
  output logic                             gnt1,
  output logic                             replay1,
  output logic [NUM_BANKS-1:0]             rd_en,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  rd_row
);

  logic same_bank;

  always_comb begin
    same_bank = req0 && req1 && (bank0 == bank1);
    gnt0      = req0;
    gnt1      = req1 && !same_bank;
    replay1   = same_bank;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    logic hit0, hit1;
    always_comb begin
      hit0      = gnt0 && (bank0 == BANK_W'(b));
      hit1      = gnt1 && (bank1 == BANK_W'(b));
      rd_en[b]  = hit0 || hit1;
      rd_row[b] = hit0 ? row0 : row1;
    end
  end

  // R3
  one_read_per_bank_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_en) || ($countones(rd_en) == 2 && gnt0 && gnt1));
  // R3
  loser_replays_chk: assert property (@(posedge clk) disable iff (rst)
    (req0 && req1 && bank0 == bank1) |-> (gnt0 && !gnt1 && replay1));
  // R4
  port0_always_wins_chk: assert property (@(posedge clk) disable iff (rst)
    req0 |-> gnt0);
  // R9
  replay_only_when_denied_chk: assert property (@(posedge clk) disable iff (rst)
    replay1 |-> (req1 && !gnt1 && req0));

endmodule

// File: rtl/bank_mem.sv
module bank_mem #(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned W     = 144
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic             re,
  input  logic [ROW_W-1:0] raddr,
  output logic [W-1:0]     q
);

  localparam int unsigned DEPTH = 1 << ROW_W;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= store[raddr];
  end

endmodule

// File: rtl/ret_pipe.sv
module ret_pipe
  import lda_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 16,
  parameter int unsigned BANK_W     = 4,
  parameter int unsigned BANK_BYTES = 16
) (
  input  logic                                               clk,
  input  logic                                               rst,
  input  logic                                               acc,
  input  logic [BANK_W-1:0]                                  bank,
  input  logic [NUM_BANKS-1:0][BANK_BYTES*(BYTE_W+1)-1:0]    bank_q,
  output logic                                               out_valid,
  output logic [BANK_BYTES*BYTE_W-1:0]                       out_data,
  output logic                                               out_perr
);

  localparam int unsigned DATA_W = BANK_BYTES * BYTE_W;

  logic                  v1, v2, v3;
  logic [BANK_W-1:0]     b1;
  logic [DATA_W-1:0]     d2, d3;
  logic [BANK_BYTES-1:0] p2, p2_calc;
  logic                  e3;

  // stage 1 runs alongside the bank read register
  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= acc;
    b1 <= bank;
  end

  // stage 2: pick this port's bank word
  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
    {p2, d2} <= bank_q[b1];
  end

  for (genvar i = 0; i < BANK_BYTES; i++) begin : g_par
    assign p2_calc[i] = ^d2[i*BYTE_W +: BYTE_W];
  end

  // stage 3: parity compare
  always_ff @(posedge clk) begin
    if (rst) begin
      v3 <= 1'b0;
      e3 <= 1'b0;
    end else begin
      v3 <= v2;
      e3 <= v2 && (|(p2_calc ^ p2));
    end
    d3 <= d2;
  end

  // stage 4: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_perr  <= 1'b0;
    end else begin
      out_valid <= v3;
      out_perr  <= e3;
    end
    out_data <= d3;
  end

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                             since_rst <= '0;
    else if (since_rst != 3'(LOAD_LAT))  since_rst <= since_rst + 3'd1;
  end

  // R5
  fixed_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'(LOAD_LAT)) |-> (out_valid == $past(acc, 4)));
  // R7
  perr_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    out_perr |-> out_valid);

endmodule

// File: rtl/bank_load_arb.sv
module bank_load_arb
  import lda_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 16,
  parameter int unsigned BANK_BYTES = 16,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fill_en,
  input  logic [ADDR_W-1:0]            fill_addr,
  input  logic [BANK_BYTES*8-1:0]      fill_data,
  input  logic [BANK_BYTES-1:0]        fill_par_flip,
  input  logic                         ld0_req,
  input  logic [ADDR_W-1:0]            ld0_addr,
  input  logic                         ld1_req,
  input  logic [ADDR_W-1:0]            ld1_addr,
  output logic                         ld0_gnt,
  output logic                         ld1_gnt,
  output logic                         ld1_replay,
  output logic                         rd0_valid,
  output logic [BANK_BYTES*8-1:0]      rd0_data,
  output logic                         rd0_perr,
  output logic                         rd1_valid,
  output logic [BANK_BYTES*8-1:0]      rd1_data,
  output logic                         rd1_perr
);

  localparam int unsigned DATA_W = BANK_BYTES * BYTE_W;
  localparam int unsigned WORD_W = DATA_W + BANK_BYTES;
  localparam int unsigned OFF_W  = $clog2(BANK_BYTES);
  localparam int unsigned BANK_W = $clog2(NUM_BANKS);
  localparam int unsigned ROW_W  = ADDR_W - OFF_W - BANK_W;

  logic [BANK_W-1:0] bank0, bank1, fill_bank;
  logic [ROW_W-1:0]  row0, row1, fill_row;

  assign bank0     = ld0_addr[OFF_W +: BANK_W];
  assign bank1     = ld1_addr[OFF_W +: BANK_W];
  assign fill_bank = fill_addr[OFF_W +: BANK_W];
  assign row0      = ld0_addr[ADDR_W-1 -: ROW_W];
  assign row1      = ld1_addr[ADDR_W-1 -: ROW_W];
  assign fill_row  = fill_addr[ADDR_W-1 -: ROW_W];

  logic unused_offset_bits;
  assign unused_offset_bits = ^{ld0_addr[OFF_W-1:0], ld1_addr[OFF_W-1:0],
                                fill_addr[OFF_W-1:0]};

  logic [NUM_BANKS-1:0]            rd_en;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rd_row;

  bank_arb #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ROW_W     (ROW_W)
  ) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req0    (ld0_req),
    .bank0   (bank0),
    .row0    (row0),
    .req1    (ld1_req),
    .bank1   (bank1),
    .row1    (row1),
    .gnt0    (ld0_gnt),
    .gnt1    (ld1_gnt),
    .replay1 (ld1_replay),
    .rd_en   (rd_en),
    .rd_row  (rd_row)
  );

  // parity generation for fills
  logic [BANK_BYTES-1:0] fill_par;
  for (genvar i = 0; i < BANK_BYTES; i++) begin : g_fpar
    assign fill_par[i] = (^fill_data[i*BYTE_W +: BYTE_W]) ^ fill_par_flip[i];
  end

  logic [WORD_W-1:0] fill_word;
  assign fill_word = {fill_par, fill_data};

  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic we_b;
    assign we_b = fill_en && (fill_bank == BANK_W'(b));
    bank_mem #(
      .ROW_W (ROW_W),
      .W     (WORD_W)
    ) u_mem (
      .clk   (clk),
      .we    (we_b),
      .waddr (fill_row),
      .wdata (fill_word),
      .re    (rd_en[b]),
      .raddr (rd_row[b]),
      .q     (bank_q[b])
    );
  end

  ret_pipe #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_W     (BANK_W),
    .BANK_BYTES (BANK_BYTES)
  ) u_ret0 (
    .clk       (clk),
    .rst       (rst),
    .acc       (ld0_gnt),
    .bank      (bank0),
    .bank_q    (bank_q),
    .out_valid (rd0_valid),
    .out_data  (rd0_data),
    .out_perr  (rd0_perr)
  );

  ret_pipe #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_W     (BANK_W),
    .BANK_BYTES (BANK_BYTES)
  ) u_ret1 (
    .clk       (clk),
    .rst       (rst),
    .acc       (ld1_gnt),
    .bank      (bank1),
    .bank_q    (bank_q),
    .out_valid (rd1_valid),
    .out_data  (rd1_data),
    .out_perr  (rd1_perr)
  );

  // R2
  distinct_banks_both_go_chk: assert property (@(posedge clk) disable iff (rst)
    (ld0_req && ld1_req && bank0 != bank1) |-> (ld0_gnt && ld1_gnt && !ld1_replay));
  // R4
  lone_port1_granted_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld0_req && ld1_req) |-> (ld1_gnt && !ld1_replay));

endmodule

// File: tb/test_bank_load_arb.sv
module test_bank_load_arb;

  logic         clk = 1'b0;
  logic         rst;
  logic         fill_en;
  logic [11:0]  fill_addr;
  logic [127:0] fill_data;
  logic [15:0]  fill_par_flip;
  logic         ld0_req, ld1_req;
  logic [11:0]  ld0_addr, ld1_addr;
  logic         ld0_gnt, ld1_gnt, ld1_replay;
  logic         rd0_valid, rd1_valid, rd0_perr, rd1_perr;
  logic [127:0] rd0_data, rd1_data;

  bank_load_arb i_bank_load_arb (
    .clk(clk), .rst(rst), .fill_en(fill_en), .fill_addr(fill_addr),
    .fill_data(fill_data), .fill_par_flip(fill_par_flip),
    .ld0_req(ld0_req), .ld0_addr(ld0_addr), .ld1_req(ld1_req), .ld1_addr(ld1_addr),
    .ld0_gnt(ld0_gnt), .ld1_gnt(ld1_gnt), .ld1_replay(ld1_replay),
    .rd0_valid(rd0_valid), .rd0_data(rd0_data), .rd0_perr(rd0_perr),
    .rd1_valid(rd1_valid), .rd1_data(rd1_data), .rd1_perr(rd1_perr)
  );

  always #10 clk = ~clk;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned cyc = 0;

  logic [127:0] mdata [16][16];
  logic [15:0]  mflip [16][16];

  logic         ev0 [8], ev1 [8], ee0 [8], ee1 [8];
  logic [127:0] ed0 [8], ed1 [8];

  task automatic chk(input logic ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [3:0] bank_of(input logic [11:0] a);
    return a[7:4];
  endfunction
  function automatic logic [3:0] row_of(input logic [11:0] a);
    return a[11:8];
  endfunction

  task automatic do_cycle(input logic fe, input logic [11:0] fa, input logic [127:0] fd,
                          input logic [15:0] ff, input logic r0, input logic [11:0] a0,
                          input logic r1, input logic [11:0] a1);
    int s, n;
    logic conf, g1;
    @(negedge clk);
    s = cyc % 8;
    // returns due this cycle (R5, R1, R2, R7)
    chk(rd0_valid == ev0[s], "R5 port0 valid", 128'(rd0_valid), 128'(ev0[s]));
    chk(rd1_valid == ev1[s], "R5 port1 valid", 128'(rd1_valid), 128'(ev1[s]));
    if (ev0[s]) begin
      chk(rd0_data == ed0[s], "R1/R2 port0 data", rd0_data, ed0[s]);
      chk(rd0_perr == ee0[s], "R7 port0 perr", 128'(rd0_perr), 128'(ee0[s]));
    end else chk(rd0_perr == 1'b0, "R7 port0 perr idle", 128'(rd0_perr), 128'd0);
    if (ev1[s]) begin
      chk(rd1_data == ed1[s], "R1/R2 port1 data", rd1_data, ed1[s]);
      chk(rd1_perr == ee1[s], "R7 port1 perr", 128'(rd1_perr), 128'(ee1[s]));
    end else chk(rd1_perr == 1'b0, "R7 port1 perr idle", 128'(rd1_perr), 128'd0);
    ev0[s] = 1'b0; ev1[s] = 1'b0;
    fill_en = fe; fill_addr = fa; fill_data = fd; fill_par_flip = ff;
    ld0_req = r0; ld0_addr = a0; ld1_req = r1; ld1_addr = a1;
    #1;
    conf = r0 && r1 && (bank_of(a0) == bank_of(a1));
    g1 = r1 && !conf;
    chk(ld0_gnt == r0, "R4 port0 grant", 128'(ld0_gnt), 128'(r0));
    chk(ld1_gnt == g1, conf ? "R3 port1 denied" : "R2/R4 port1 grant",
        128'(ld1_gnt), 128'(g1));
    chk(ld1_replay == conf, conf ? "R3 replay" : "R9 no replay",
        128'(ld1_replay), 128'(conf));
    n = (cyc + 4) % 8;
    if (!rst) begin
      if (r0) begin
        ev0[n] = 1'b1;
        ed0[n] = mdata[bank_of(a0)][row_of(a0)];
        ee0[n] = |mflip[bank_of(a0)][row_of(a0)];
      end
      if (g1) begin
        ev1[n] = 1'b1;
        ed1[n] = mdata[bank_of(a1)][row_of(a1)];
        ee1[n] = |mflip[bank_of(a1)][row_of(a1)];
      end
      if (fe) begin
        mdata[bank_of(fa)][row_of(fa)] = fd;
        mflip[bank_of(fa)][row_of(fa)] = ff;
      end
    end
    cyc++;
  endtask

  task automatic idle();
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b0, 12'h0, 1'b0, 12'h0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic        pend;
    logic [11:0] paddr;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 8; i++) begin
      ev0[i] = 0; ev1[i] = 0; ee0[i] = 0; ee1[i] = 0; ed0[i] = '0; ed1[i] = '0;
    end
    rst = 1'b1;
    // R8: outputs quiet during reset, even with requests present
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b1, 12'h010, 1'b1, 12'h020);
    idle(); idle(); idle(); idle();
    rst = 1'b0;
    // R8: checked in the idle cycles right after release
    idle(); idle();

    // R6: fill every bank word, planting parity faults on some
    for (int b = 0; b < 16; b++)
      for (int r = 0; r < 16; r++) begin
        logic [127:0] d;
        logic [15:0]  f;
        d = {$urandom, $urandom, $urandom, $urandom};
        f = (($urandom % 8) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
        do_cycle(1'b1, {4'(r), 4'(b), 4'($urandom % 16)}, d, f,
                 1'b0, 12'h0, 1'b0, 12'h0);
      end
    // directed faulty entry: bank 5 row 2, byte 2 parity inverted (R6/R7)
    do_cycle(1'b1, 12'h250, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
             16'h0004, 1'b0, 12'h0, 1'b0, 12'h0);
    // directed clean entry: bank 6 row 2 (R6)
    do_cycle(1'b1, 12'h260, 128'hFFFF_0000_AAAA_5555_1234_5678_9ABC_DEF0,
             16'h0000, 1'b0, 12'h0, 1'b0, 12'h0);
    idle();

    // R3: same bank 3, different rows and offsets; replay then re-present
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b1, 12'h135, 1'b1, 12'h73A);
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b0, 12'h000, 1'b1, 12'h73A);
    // R2: different banks in the same cycle
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b1, 12'h250, 1'b1, 12'h260);
    // R1: same bank/row, offsets differ, same word
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b1, 12'h26F, 1'b0, 12'h0);
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b1, 12'h261, 1'b0, 12'h0);
    // R4: port 1 alone
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b0, 12'h0, 1'b1, 12'h25C);
    // R3: back-to-back conflicts on bank 9
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b1, 12'h090, 1'b1, 12'hF92);
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b1, 12'h194, 1'b1, 12'hF92);
    do_cycle(1'b0, 12'h0, 128'h0, 16'h0, 1'b0, 12'h0, 1'b1, 12'hF92);
    for (int i = 0; i < 6; i++) idle();

    // random traffic with replays honoured
    pend = 1'b0; paddr = '0;
    for (int i = 0; i < 4000; i++) begin
      logic        r0, r1;
      logic [11:0] a0, a1;
      logic [3:0]  b0, b1;
      r0 = ($urandom % 4) != 0;
      b0 = ($urandom % 3 != 0) ? 4'($urandom % 3) : 4'($urandom % 16);
      a0 = {4'($urandom % 16), b0, 4'($urandom % 16)};
      if (pend) begin
        r1 = 1'b1; a1 = paddr;
      end else begin
        r1 = ($urandom % 4) != 0;
        b1 = ($urandom % 3 != 0) ? 4'($urandom % 3) : 4'($urandom % 16);
        a1 = {4'($urandom % 16), b1, 4'($urandom % 16)};
      end
      do_cycle(1'b0, 12'h0, 128'h0, 16'h0, r0, a0, r1, a1);
      pend = ld1_replay;
      paddr = a1;
    end
    for (int i = 0; i < 6; i++) idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule